// File: doc/BRIEF.md
# Block-Transfer Configuration Register Target on a Two-Wire Bus

This block is a two-wire serial bus target that holds a bank of six configuration bytes and presents them to the rest of the chip as one flat parallel vector. The bus lines are sampled with the system clock. Each line passes through a two-flop synchronizer and a counter-based glitch filter. Start and stop conditions are then detected from the filtered levels. The block drives the data line only by pulling it low through an output-enable.

Access to the bank is by whole-bank block transfers only, and there is no register pointer.

- **Write:** the host sends the write address, then two placeholder bytes that are acknowledged and discarded, then data bytes. The data bytes land in byte 0, byte 1 and so on.
- **Read:** the host sends the read address. The block answers with a byte count and then the six bytes in ascending order.

A stop after any complete byte ends a write. The bytes already written keep their new values and the others stay as they were. Reset loads fixed default values into every byte.

Top module: `cfgi2c_slave`

## Requirements
- R1: The block acknowledges only the address byte 0xD2 (write) or 0xD3 (read), that is, 7-bit address 0x69 with the R/W flag in bit 0 (1 = read). For any other address it does not acknowledge, leaves SDA released and changes no byte until the next start.
- R2: In a write, the first two bytes after the address are acknowledged, and their values change no byte of the bank.
- R3: The data bytes of a write are stored in rising order starting at byte 0. Byte i of the bank appears on `cfg_o[8*i+7:8*i]`, and each bus byte is shifted MSB first.
- R4: A stop after any complete data byte ends the write. The bytes written so far keep their new values and all later bytes keep their previous values.
- R5: Every byte received in an addressed write is acknowledged, including bytes beyond the sixth data byte. Those extra bytes change nothing.
- R6: In a read, after acknowledging the address, the block sends the byte count 6 (0x06) and then bytes 0 to 5 in order, MSB first, each followed by a host acknowledge bit.
- R7: A host NACK ends the read. The block then leaves SDA released, so further clocks read 0xFF, until the next start.
- R8: While reset is asserted, and right after it is released, `cfg_o` equals the defaults 0xF00FFFC3815A (byte 0 = 0x5A ... byte 5 = 0xF0) and SDA is released.
- R9: A start, including a repeated start inside a transfer, restarts the transfer at the address byte. After a repeated start, the next write again skips two placeholder bytes and stores from byte 0. A stop returns the block to idle.
- R10: The block begins to pull SDA low only while SCL is low.
- R11: A pulse on SCL that lasts fewer than FILT_LEN (3) system clocks is ignored and does not count as a bus clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset; loads the defaults |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | 1 = pull the data line low; 0 = release it |
| cfg_o | output | 48 | Bank contents, byte i at bits 8*i+7..8*i |

## Verification
The bench goes after several corner cases, and each one has a recognisable failure signature:
- **Placeholder bytes:** a design that skips the wrong number of them stores every data byte one register off.
- **Stop after a partial write:** a design that commits late loses the last byte, and one that clears unwritten bytes destroys old values.
- **Overlong writes:** these catch an index that wraps or stops acknowledging.
- **Read after a host NACK:** a design that keeps driving returns data in place of 0xFF.
- **Repeated start mid-write:** this exposes a sequencer that keeps its byte index.
- **Short SCL pulse:** an unfiltered design shifts in a phantom bit and fails to acknowledge its own address.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT
  } seq_st_e;

  localparam logic [7:0] RELEASED_BYTE = 8'hFF;

endpackage

// File: rtl/cfgi2c_line_filter.sv
module cfgi2c_line_filter #(
  parameter int unsigned FILT_LEN = 3,
  parameter logic        IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  localparam int unsigned CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [1:0]       sync_q;
  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sync_q[1] != filt_q) begin
      if (cnt_q == CNT_LAST) begin
        filt_d = sync_q[1];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{IDLE_LVL}};
      filt_q <= IDLE_LVL;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign line_o = filt_q;

  AST_FILT_RISE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> $past(sync_q[1])); // R11
  AST_FILT_FALL_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> !$past(sync_q[1])); // R11

endmodule

// File: rtl/cfgi2c_cond_detect.sv
module cfgi2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned IDX_W    = 4,
  parameter logic [NUM_REGS*8-1:0] RST_VAL = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);

  import cfgi2c_pkg::*;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic       hit;
    logic [7:0] r_q, r_d;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      r_d = r_q;
      if (hit) r_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= RST_VAL[8*g +: 8];
      else        r_q <= r_d;
    end

    assign regs_o[8*g +: 8] = r_q;
  end

  always_comb begin
    rd_data = RELEASED_BYTE;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = regs_o[8*i +: 8];
    end
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R2

endmodule

// File: rtl/cfgi2c_seq.sv
module cfgi2c_seq #(
  parameter int unsigned NUM_REGS  = 6,
  parameter int unsigned HDR_BYTES = 2,
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);

  import cfgi2c_pkg::*;

  localparam logic [IDX_W-1:0] HDR_END = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] WR_END  = IDX_W'(HDR_BYTES + NUM_REGS);
  localparam logic [IDX_W-1:0] RD_END  = IDX_W'(NUM_REGS);
  localparam logic [7:0]       COUNT_BYTE = 8'(NUM_REGS);

  seq_st_e          st_q, st_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             is_addr_q, is_addr_d;
  logic             rd_q, rd_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d      = st_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    is_addr_d = is_addr_q;
    rd_d      = rd_q;
    cnt_d     = cnt_q;
    wr_en     = 1'b0;
    if (start_p) begin
      st_d      = ST_RX;
      bit_d     = '0;
      cnt_d     = '0;
      is_addr_d = 1'b1;
      rd_d      = 1'b0;
    end else if (stop_p) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_lvl};
            if (bit_q == 3'd7) st_d = ST_RX_END;
            else               bit_d = bit_q + 3'd1;
          end
        end
        ST_RX_END: begin
          if (scl_fall) begin
            if (is_addr_q) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                st_d = ST_RX_ACK;
                rd_d = sh_q[0];
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              st_d  = ST_RX_ACK;
              wr_en = (cnt_q >= HDR_END) && (cnt_q < WR_END);
              if (cnt_q < WR_END) cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            is_addr_d = 1'b0;
            bit_d     = '0;
            if (rd_q) begin
              st_d  = ST_TX;
              sh_d  = COUNT_BYTE;
              cnt_d = '0;
            end else begin
              st_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              st_d = ST_TX_ACK;
            end else begin
              bit_d = bit_q + 3'd1;
              sh_d  = {sh_q[6:0], 1'b1};
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            st_d = sda_lvl ? ST_IDLE : ST_TX_NEXT;
          end
        end
        ST_TX_NEXT: begin
          if (scl_fall) begin
            st_d  = ST_TX;
            bit_d = '0;
            sh_d  = (cnt_q < RD_END) ? rd_data : RELEASED_BYTE;
            if (cnt_q < RD_END) cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      is_addr_q <= 1'b0;
      rd_q      <= 1'b0;
      cnt_q     <= '0;
    end else begin
      st_q      <= st_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      is_addr_q <= is_addr_d;
      rd_q      <= rd_d;
      cnt_q     <= cnt_d;
    end
  end

  assign sda_oe  = (st_q == ST_RX_ACK) || ((st_q == ST_TX) && !sh_q[7]);
  assign rd_idx  = cnt_q;
  assign wr_idx  = cnt_q - HDR_END;
  assign wr_data = sh_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl); // R10
  AST_HOST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX_ACK) |-> !sda_oe); // R7
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (st_q == ST_RX) && (bit_q == 3'd0) && (cnt_q == '0)); // R9
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_p && !start_p) |=> (st_q == ST_IDLE) && !sda_oe); // R9
  AST_ADDR_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RX_END) && is_addr_q && scl_fall && !start_p && !stop_p &&
     (sh_q[7:1] != DEV_ADDR)) |=> !sda_oe); // R1

endmodule

// File: rtl/cfgi2c_slave.sv
module cfgi2c_slave #(
  parameter int unsigned NUM_REGS  = 6,
  parameter int unsigned HDR_BYTES = 2,
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  parameter int unsigned FILT_LEN  = 3,
  parameter logic [NUM_REGS*8-1:0] RST_VAL = 48'hF00FFFC3815A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  localparam int unsigned IDX_W = $clog2(HDR_BYTES + NUM_REGS + 1);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [1:0] line_raw, line_flt;
  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    cfgi2c_line_filter #(
      .FILT_LEN (FILT_LEN),
      .IDLE_LVL (1'b1)
    ) filt_i (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .line_i (line_raw[g]),
      .line_o (line_flt[g])
    );
  end

  logic scl_rise, scl_fall, start_p, stop_p;

  cfgi2c_cond_detect cond_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .scl_i      (line_flt[0]),
    .sda_i      (line_flt[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [7:0]       rd_data, wr_data;
  logic             wr_en;

  cfgi2c_seq #(
    .NUM_REGS  (NUM_REGS),
    .HDR_BYTES (HDR_BYTES),
    .DEV_ADDR  (DEV_ADDR),
    .IDX_W     (IDX_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_lvl  (line_flt[0]),
    .sda_lvl  (line_flt[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe_o)
  );

  cfgi2c_regbank #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .RST_VAL  (RST_VAL)
  ) bank_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .regs_o  (cfg_o)
  );

endmodule

// File: tb/cfgi2c_slave_tb_top.sv
module cfgi2c_slave_tb_top;

  localparam int CLK_PERIOD_NS = 10;
  localparam int Q = 12;
  localparam logic [47:0] DEF_CFG = 48'hF00FFFC3815A;
  // {number of data bytes, data bytes with byte 0 in the low octet}
  localparam logic [71:0] VEC [4] = '{
    {8'd6, 64'h0000_1122_3344_5566},
    {8'd3, 64'h0000_0000_00AB_CDEF},
    {8'd0, 64'h0000_0000_0000_0000},
    {8'd8, 64'h9988_7766_5544_3322}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [47:0] cfg;

  int n_chk = 0;
  int n_bad = 0;
  int oe_viol = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;

  assign sda_line = sda_h & ~sda_oe;

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  cfgi2c_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_h),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .cfg_o    (cfg)
  );

  // R10 monitor: a new pull-down must not begin while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_h) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int k);
    repeat (k*Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wq(1); scl_h = 1'b1; wq(1); sda_h = 1'b0; wq(1); scl_h = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(1); scl_h = 1'b1; wq(1); sda_h = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq(1); scl_h = 1'b1; wq(2); scl_h = 1'b0; wq(1);
    end
    sda_h = 1'b1; wq(1); scl_h = 1'b1; wq(1);
    acked = !sda_line;
    wq(1); scl_h = 1'b0; wq(1);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    for (int i = 7; i >= 0; i--) begin
      wq(1); scl_h = 1'b1; wq(1); b[i] = sda_line; wq(1); scl_h = 1'b0;
    end
    wq(1); sda_h = ack ? 1'b0 : 1'b1; wq(1); scl_h = 1'b1; wq(2); scl_h = 1'b0; wq(1); sda_h = 1'b1;
  endtask

  task automatic glitch_scl();
    scl_h = 1'b1; repeat (2) @(negedge clk); scl_h = 1'b0; wq(1);
  endtask

  initial begin
    logic [47:0] exp_cfg;
    logic [7:0]  rb;
    bit          ak;
    bit          all_ak;

    repeat (5) @(negedge clk);
    chk(cfg == DEF_CFG, "R8 defaults during reset", 64'(cfg), 64'(DEF_CFG));
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(cfg == DEF_CFG && !sda_oe, "R8 defaults after reset", {15'd0, sda_oe, cfg}, {16'd0, DEF_CFG});
    exp_cfg = DEF_CFG;

    // Table walk: block write, then full block read-back
    for (int v = 0; v < 4; v++) begin
      int n;
      logic [63:0] d;
      logic [47:0] got;
      n = int'(VEC[v][71:64]);
      d = VEC[v][63:0];
      all_ak = 1'b1;
      bus_start();
      send_byte(8'hD2, ak); all_ak &= ak;
      send_byte(8'h40 + 8'(v), ak); all_ak &= ak;  // R2 placeholder command
      send_byte(8'h03 - 8'(v), ak); all_ak &= ak;  // R2 placeholder count
      for (int i = 0; i < n; i++) begin
        send_byte(d[8*i +: 8], ak); all_ak &= ak;
        if (i < 6) exp_cfg[8*i +: 8] = d[8*i +: 8];
      end
      bus_stop();
      chk(all_ak, "R5 every write byte acknowledged", 64'(all_ak), 64'd1);
      chk(cfg == exp_cfg, "R2/R3/R4 bank after write", 64'(cfg), 64'(exp_cfg));
      bus_start();
      send_byte(8'hD3, ak);
      recv_byte(rb, 1'b1);
      chk(ak && rb == 8'h06, "R6 read count byte", {55'd0, ak, rb}, {55'd0, 1'b1, 8'h06});
      for (int i = 0; i < 6; i++) begin
        recv_byte(rb, i != 5);
        got[8*i +: 8] = rb;
      end
      bus_stop();
      chk(got == exp_cfg, "R6 read data bytes", 64'(got), 64'(exp_cfg));
    end

    // R1: foreign address is ignored
    bus_start();
    send_byte(8'hA4, ak);
    chk(!ak, "R1 foreign address not acknowledged", 64'(ak), 64'd0);
    send_byte(8'h00, all_ak);
    send_byte(8'h12, all_ak);
    send_byte(8'h34, all_ak);
    bus_stop();
    chk(cfg == exp_cfg, "R1 foreign transfer leaves bank", 64'(cfg), 64'(exp_cfg));

    // R7: host NACK mid-read releases the line
    bus_start();
    send_byte(8'hD3, ak);
    recv_byte(rb, 1'b1);
    recv_byte(rb, 1'b1);
    recv_byte(rb, 1'b0);
    chk(rb == exp_cfg[15:8], "R7 byte before NACK", 64'(rb), 64'(exp_cfg[15:8]));
    recv_byte(rb, 1'b0);
    chk(rb == 8'hFF, "R7 line released after NACK", 64'(rb), 64'hFF);
    bus_stop();

    // R9: repeated start inside a write restarts the sequence
    bus_start();
    send_byte(8'hD2, ak); send_byte(8'hEE, ak); send_byte(8'hEE, ak);
    send_byte(8'h11, ak);
    chk(cfg[7:0] == 8'h11, "R4 first byte committed before restart", 64'(cfg[7:0]), 64'h11);
    bus_start();
    send_byte(8'hD2, ak); send_byte(8'hC0, ak); send_byte(8'h02, ak);
    send_byte(8'h22, ak); send_byte(8'h33, ak);
    bus_stop();
    exp_cfg[15:0] = 16'h3322;
    chk(cfg == exp_cfg, "R9 restart writes from byte 0", 64'(cfg), 64'(exp_cfg));

    // R11: short SCL pulses are not bus clocks
    bus_start();
    glitch_scl();
    send_byte(8'hD2, ak);
    chk(ak, "R11 address acked despite SCL glitch", 64'(ak), 64'd1);
    glitch_scl();
    send_byte(8'h5A, ak); send_byte(8'hA5, ak);
    glitch_scl();
    send_byte(8'h3C, ak);
    bus_stop();
    exp_cfg[7:0] = 8'h3C;
    chk(cfg == exp_cfg, "R11 bank after glitched write", 64'(cfg), 64'(exp_cfg));

    chk(oe_viol == 0, "R10 pull-down began with SCL high", 64'(oe_viol), 64'd0);

    // R8: reset in mid-life restores defaults
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(cfg == DEF_CFG && !sda_oe, "R8 reset restores defaults", {15'd0, sda_oe, cfg}, {16'd0, DEF_CFG});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule